// File: doc/BRIEF.md
# Split-Field Binary Logarithm Unit

This unit takes the 23-bit fraction `f` of a normalized mantissa `1.f` and returns the 22-bit fixed-point fraction of `log2(1.f)`. It serves as the logarithm stage of a log-domain arithmetic datapath. The sign and exponent are handled by the surrounding logic.

The input word is cut into a 10-bit head field and a 13-bit tail field. The head field addresses one table. That table returns the logarithm of the head value `1.h` and the reciprocal of `1.h`. The tail field is multiplied by this reciprocal, and the product is scaled down by the fixed shift that the 13-bit tail position implies. The result is the small ratio `d`, with `1.f = 1.h · (1 + d)`. The upper bits of `d` address a second, much smaller table that holds `log2(1 + d)`. The lowest bits of `d` are folded in as a linear term scaled by `1/ln 2`.

The partial results are summed at 28 fraction bits and rounded to 22 bits. Both tables are computed at elaboration by integer routines. The unit has three register stages and accepts one input on every clock.

Top module: `digit_split_log2`

## Requirements
- R1: `out_valid` equals the value that `in_valid` had three rising clock edges earlier. Each accepted input yields exactly one result.
- R2: While `rst` is high (synchronous, active high), and in the first cycle after `rst` is released, `out_valid` is 0 and `out_log` is 0.
- R3: For any 23-bit input `f`, `out_log` differs by at most 1 from `round(log2(1 + f/2^23) · 2^22)`, the correctly rounded value. The result is an unsigned fraction with weight 2^-22 per LSB.
- R4: An input of `f = 0` produces `out_log = 0` exactly.
- R5: The largest input, `f = 2^23 - 1`, produces `out_log = 2^22 - 1`. The output saturates at all ones and never wraps to a small value.
- R6: While `out_valid` is 0, `out_log` keeps the last result it presented, or 0 if no result has been presented since reset.
- R7: Inputs presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R8: Inputs on either side of a head-field boundary meet the R3 bound. These are `f = k·2^13`, where the tail field is all zeros, and `f = k·2^13 - 1`, where the tail field is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input fraction is valid this cycle |
| in_frac | input | 23 | Mantissa fraction `f` of `1.f` |
| out_valid | output | 1 | Result valid, three cycles after the input |
| out_log | output | 22 | `log2(1.f)` as a fraction with weight 2^-22 per LSB |

## Verification
Four properties are checked on every cycle:
- the three-cycle valid latency;
- the cleared outputs just after reset;
- the exact zero result for a zero input;
- the held output while no result is valid.

The numerical accuracy bound cannot be expressed as a property. It is shown only by the bench's reference model across edge inputs, values on both sides of each head-field boundary, and long random runs. The same applies to the saturation of the largest input and to result ordering under back-to-back traffic.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    localparam int FRAC_W   = 23;
    localparam int HI_W     = 10;
    localparam int LO_W     = FRAC_W - HI_W;
    localparam int OUT_W    = 22;
    localparam int ACC_F    = 28;
    localparam int RCP_F    = 16;
    localparam int TAIL_W   = 9;
    localparam int ONE_SH   = 30;
    localparam int DW       = ACC_F - HI_W;
    localparam int TLO_W    = DW - TAIL_W;
    localparam int PROD_W   = LO_W + RCP_F + 1;
    localparam int DSH      = FRAC_W + RCP_F - ACC_F;
    localparam int KLN_W    = 13;
    localparam int KLN_SH   = 12;
    localparam int KLN      = 5909;
    localparam int RSQ_W    = TLO_W + KLN_W;
    localparam int RES_W    = RSQ_W - KLN_SH;
    localparam int RSH      = ACC_F - OUT_W;

    typedef struct packed {
        logic              v1;
        logic [ACC_F-1:0]  ya1;
        logic [RCP_F:0]    rc1;
        logic [LO_W-1:0]   lo1;
        logic              v2;
        logic [ACC_F:0]    sum2;
        logic              v3;
        logic [OUT_W-1:0]  y3;
    } pipe_t;

    // Fractional log2 of a Q30 value in [1,2), rounded to ACC_F bits,
    // found bit by bit through repeated squaring.
    function automatic logic [ACC_F-1:0] log2_frac(input logic [63:0] m_in);
        logic [63:0] m;
        logic [ACC_F:0] bits;
        m    = m_in;
        bits = '0;
        for (int j = 0; j <= ACC_F; j++) begin
            m    = (m * m) >> ONE_SH;
            bits = {bits[ACC_F-1:0], 1'b0};
            if (m >= (64'd2 << ONE_SH)) begin
                bits[0] = 1'b1;
                m       = m >> 1;
            end
        end
        return ACC_F'(({1'b0, bits} + (ACC_F+2)'(1)) >> 1);
    endfunction

    // Rounded reciprocal of 1.h with RCP_F fraction bits.
    function automatic logic [RCP_F:0] recip_hi(input logic [63:0] h);
        logic [63:0] q;
        q = (64'd1 << (RCP_F + HI_W + 1)) / ((64'd1 << HI_W) + h);
        return (RCP_F+1)'((q + 64'd1) >> 1);
    endfunction

endpackage

// File: rtl/dsl_head_rom.sv
module dsl_head_rom
    import dsl_pkg::*;
(
    input  logic [HI_W-1:0]  idx,
    output logic [ACC_F-1:0] ya,
    output logic [RCP_F:0]   rcp
);

    localparam int N = 1 << HI_W;

    logic [ACC_F-1:0] ya_tab  [N];
    logic [RCP_F:0]   rcp_tab [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign ya_tab[i]  = log2_frac(((64'd1 << HI_W) + 64'(i)) << (ONE_SH - HI_W));
        assign rcp_tab[i] = recip_hi(64'(i));
    end

    assign ya  = ya_tab[idx];
    assign rcp = rcp_tab[idx];

endmodule

// File: rtl/dsl_tail_rom.sv
module dsl_tail_rom
    import dsl_pkg::*;
(
    input  logic [TAIL_W-1:0] idx,
    output logic [ACC_F-1:0]  yb
);

    localparam int N = 1 << TAIL_W;

    logic [ACC_F-1:0] yb_tab [N];

    // Entry i holds log2(1 + i * 2^-(ACC_F - TLO_W)).
    for (genvar i = 0; i < N; i++) begin : g_ent
        assign yb_tab[i] = log2_frac((64'd1 << ONE_SH) + (64'(i) << (ONE_SH - ACC_F + TLO_W)));
    end

    assign yb = yb_tab[idx];

endmodule

// File: rtl/digit_split_log2.sv
module digit_split_log2
    import dsl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FRAC_W-1:0] in_frac,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_log
);

    localparam int HALF = 1 << (RSH - 1);

    pipe_t st_d, st_q;

    logic [ACC_F-1:0]  hi_ya;
    logic [RCP_F:0]    hi_rcp;
    logic [PROD_W-1:0] prod;
    logic [DW-1:0]     d_w;
    logic [ACC_F-1:0]  tail_yb;
    logic [RES_W-1:0]  resid;
    logic [OUT_W:0]    rnd;

    dsl_head_rom u_head (
        .idx (in_frac[FRAC_W-1:LO_W]),
        .ya  (hi_ya),
        .rcp (hi_rcp)
    );

    // Ratio d = tail / (1.head), scaled to ACC_F fraction bits.
    assign prod  = PROD_W'(st_q.lo1) * PROD_W'(st_q.rc1);
    assign d_w   = DW'(prod >> DSH);
    assign resid = RES_W'((RSQ_W'(d_w[TLO_W-1:0]) * RSQ_W'(KLN)) >> KLN_SH);

    dsl_tail_rom u_tail (
        .idx (d_w[DW-1:TLO_W]),
        .yb  (tail_yb)
    );

    assign rnd = (OUT_W+1)'((st_q.sum2 + (ACC_F+1)'(HALF)) >> RSH);

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_valid;
        if (in_valid) begin
            st_d.ya1 = hi_ya;
            st_d.rc1 = hi_rcp;
            st_d.lo1 = in_frac[LO_W-1:0];
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.sum2 = (ACC_F+1)'(st_q.ya1) + (ACC_F+1)'(tail_yb) + (ACC_F+1)'(resid);
        end
        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.y3 = rnd[OUT_W] ? {OUT_W{1'b1}} : rnd[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.v3;
    assign out_log   = st_q.y3;

endmodule

// File: rtl/digit_split_log2_chk.sv
module digit_split_log2_chk
    import dsl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [FRAC_W-1:0] in_frac,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_log
);

    logic [1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)                 since_q <= 2'd0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q == 2'd1) |-> (!out_valid && out_log == '0));

    // R4
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q == 2'd3 && $past(in_valid, 3) && $past(in_frac, 3) == '0) |-> (out_log == '0));

    // R6
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q != 2'd0 && !out_valid) |=> (out_valid || $stable(out_log)));

endmodule

bind digit_split_log2 digit_split_log2_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_frac   (in_frac),
    .out_valid (out_valid),
    .out_log   (out_log)
);

// File: tb/digit_split_log2_bench.sv
module digit_split_log2_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [22:0] in_frac = '0;
    logic        out_valid;
    logic [21:0] out_log;

    always #4 clk = ~clk;

    digit_split_log2 u_digit_split_log2 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_frac   (in_frac),
        .out_valid (out_valid),
        .out_log   (out_log)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    bit    ev [3];
    int    ey [3];
    string et [3];
    string cur_tag = "R3";
    int    last_out = 0;

    function automatic int ref_log(logic [22:0] f);
        real r;
        int  e;
        r = $ln(1.0 + real'(f) / 8388608.0) / $ln(2.0);
        e = int'(r * 4194304.0);
        if (e > 4194303) e = 4194303;
        return e;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural three-deep expectation queue.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 3; i++) ev[i] <= 1'b0;
        end else begin
            ev[2] <= ev[1]; ey[2] <= ey[1]; et[2] <= et[1];
            ev[1] <= ev[0]; ey[1] <= ey[0]; et[1] <= et[0];
            ev[0] <= in_valid;
            ey[0] <= ref_log(in_frac);
            et[0] <= cur_tag;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(out_valid == ev[2], "R1", int'(out_valid), int'(ev[2]));
            if (out_valid && ev[2]) begin
                int diff;
                int tol;
                diff = int'(out_log) - ey[2];
                tol  = (et[2] == "R4" || et[2] == "R5") ? 0 : 1;
                check(diff <= tol && diff >= -tol, et[2], int'(out_log), ey[2]);
                last_out = int'(out_log);
            end else if (!out_valid) begin
                check(int'(out_log) == last_out, "R6", int'(out_log), last_out);
            end
        end
    end

    task automatic send(logic [22:0] f, string tag);
        cur_tag  = tag;
        in_valid = 1'b1;
        in_frac  = f;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && out_log == '0, "R2", int'(out_log), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && out_log == '0, "R2", int'(out_log), 0);

        send(23'd0, "R4");
        idle(5);
        send(23'h7FFFFF, "R5");
        idle(5);
        send(23'd1, "R3");
        send(23'd4096, "R3");
        send(23'h400000, "R3");
        idle(3);

        for (int j = 0; j < 64; j++) begin
            logic [22:0] b;
            b = 23'((j * 16 + 1) << 13);
            send(b, "R8");
            send(b - 23'd1, "R8");
        end
        send(23'h7FE000, "R8");
        send(23'h7FDFFF, "R8");
        idle(4);

        for (int j = 0; j < 3000; j++) send(23'($urandom), "R7");
        idle(4);

        for (int j = 0; j < 500; j++) begin
            send(23'($urandom), "R3");
            if ($urandom % 3 == 0) idle(1 + $urandom % 3);
        end
        idle(6);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R7 watchdog: got %0d cycles expected fewer", 100000);
            summary();
            $finish;
        end
    end

endmodule